// File: doc/BRIEF.md
# Inverting Bidirectional Latched Bus Transceiver

This block joins two 8-bit ports, A and B, with one storage path for each direction. Each path has three active-low controls: an enable, a load control and a drive control. While a path's enable and load are both low at a clock edge, its storage bank takes the value on the source port. When load is high, or the enable is high, the bank keeps its value. The destination port shows the bit-wise inverse of the stored word. It is driven only while that path's enable and drive control are both low.

The ports are not tri-state pins. Each port has an input vector, an output vector and an output-drive-enable vector. All bits of the drive-enable vector are set or cleared together, and a pad ring can wrap them later. Transparency is modelled as a clock-enabled register: while the path is open, the bank reloads on every edge. A rising load control closes the bank at the first edge that samples it high.

Top module: `inv_latch_xcvr`

## Requirements
- R1: A synchronous active-high `rst` clears both storage banks to zero and clears both drive-enable vectors. While a drive-enable vector is clear, its data output reads all zeros.
- R2: If `ab_en_n` and `ab_ld_n` are both low at a rising clock edge, the A-to-B bank stores `a_in` at that edge.
- R3: If `ab_ld_n` is high at an edge, the A-to-B bank keeps its contents, whatever `a_in` does.
- R4: If `ab_en_n` is high at an edge, the A-to-B bank keeps its contents, whatever `ab_ld_n` and `a_in` do.
- R5: After an edge where `ab_en_n` and `ab_drv_n` are both low, all bits of `b_oe` are 1. After any other edge, all bits of `b_oe` are 0 and `b_out` is all zeros.
- R6: While `b_oe` is set, `b_out` equals the bit-wise inverse of the A-to-B bank.
- R7: The B-to-A bank loads and holds under `ba_en_n` and `ba_ld_n` by the same rules as R2 to R4, with `b_in` as its source.
- R8: `a_oe` and `a_out` follow `ba_en_n`, `ba_drv_n` and the inverted B-to-A bank by the same rules as R5 and R6.
- R9: The two directions are independent. No control or data input of one path changes the other path's bank or outputs.
- R10: The drive control has no effect on storage. A word held while the drive control is high reappears unchanged once driving resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Value sampled from the A side |
| a_out | output | W | Value driven onto the A side (inverted B-to-A bank) |
| a_oe | output | W | Drive enable for the A side, all bits equal |
| b_in | input | W | Value sampled from the B side |
| b_out | output | W | Value driven onto the B side (inverted A-to-B bank) |
| b_oe | output | W | Drive enable for the B side, all bits equal |
| ab_en_n | input | 1 | A-to-B path enable, active low |
| ab_ld_n | input | 1 | A-to-B load control, active low (low = transparent) |
| ab_drv_n | input | 1 | A-to-B drive control, active low |
| ba_en_n | input | 1 | B-to-A path enable, active low |
| ba_ld_n | input | 1 | B-to-A load control, active low (low = transparent) |
| ba_drv_n | input | 1 | B-to-A drive control, active low |

## Verification
Every result appears exactly one clock edge after the inputs that cause it. A data word captured at edge k reads back inverted on the far port after edge k. A change on an enable or drive control shows on the drive-enable vector after the same edge. The bench changes inputs only on falling edges. A behavioural model updates on each rising edge, and the bench compares all four output vectors at the next falling edge, so each comparison sees the state that exactly one edge has produced.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned NUM_DIRS = 2;
  localparam int unsigned DIR_AB   = 0;
  localparam int unsigned DIR_BA   = 1;

  typedef struct packed {
    logic en_n;
    logic ld_n;
    logic drv_n;
  } xfer_ctrl_t;
endpackage

// File: rtl/xcvr_hold_bank.sv
module xcvr_hold_bank
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  xfer_ctrl_t   ctrl,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic open_w;
  assign open_w = ~ctrl.en_n & ~ctrl.ld_n;

  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (open_w) q <= din;
  end
endmodule

// File: rtl/xcvr_drive_stage.sv
module xcvr_drive_stage
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  xfer_ctrl_t   ctrl,
  input  logic [W-1:0] q,
  output logic [W-1:0] dout,
  output logic [W-1:0] doe
);
  logic drive_q;

  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else     drive_q <= ~ctrl.en_n & ~ctrl.drv_n;
  end

  assign doe  = {W{drive_q}};
  assign dout = drive_q ? ~q : '0;
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  xfer_ctrl_t   ctrl,
  input  logic [W-1:0] src,
  output logic [W-1:0] dst,
  output logic [W-1:0] dst_oe
);
  logic [W-1:0] held;

  xcvr_hold_bank #(.W(W)) u_bank (
    .clk(clk), .rst(rst), .ctrl(ctrl), .din(src), .q(held)
  );

  xcvr_drive_stage #(.W(W)) u_drv (
    .clk(clk), .rst(rst), .ctrl(ctrl), .q(held), .dout(dst), .doe(dst_oe)
  );
endmodule

// File: rtl/inv_latch_xcvr.sv
module inv_latch_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic         ab_en_n,
  input  logic         ab_ld_n,
  input  logic         ab_drv_n,
  input  logic         ba_en_n,
  input  logic         ba_ld_n,
  input  logic         ba_drv_n
);
  xfer_ctrl_t   ctrl_v [NUM_DIRS];
  logic [W-1:0] src_v  [NUM_DIRS];
  logic [W-1:0] dst_v  [NUM_DIRS];
  logic [W-1:0] oe_v   [NUM_DIRS];

  assign ctrl_v[DIR_AB] = '{en_n: ab_en_n, ld_n: ab_ld_n, drv_n: ab_drv_n};
  assign ctrl_v[DIR_BA] = '{en_n: ba_en_n, ld_n: ba_ld_n, drv_n: ba_drv_n};
  assign src_v[DIR_AB]  = a_in;
  assign src_v[DIR_BA]  = b_in;

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    xcvr_path #(.W(W)) u_path (
      .clk(clk), .rst(rst), .ctrl(ctrl_v[d]), .src(src_v[d]),
      .dst(dst_v[d]), .dst_oe(oe_v[d])
    );
  end

  assign b_out = dst_v[DIR_AB];
  assign b_oe  = oe_v[DIR_AB];
  assign a_out = dst_v[DIR_BA];
  assign a_oe  = oe_v[DIR_BA];
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe,
  input logic         ab_en_n,
  input logic         ab_ld_n,
  input logic         ab_drv_n,
  input logic         ba_en_n,
  input logic         ba_ld_n,
  input logic         ba_drv_n
);
  // R5
  b_oe_uniform_chk: assert property (@(posedge clk) disable iff (rst)
    (b_oe == '0) || (b_oe == '1));
  // R8
  a_oe_uniform_chk: assert property (@(posedge clk) disable iff (rst)
    (a_oe == '0) || (a_oe == '1));
  // R5
  b_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (b_oe == '0) |-> (b_out == '0));
  // R8
  a_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (a_oe == '0) |-> (a_out == '0));
  // R5
  b_drive_on_chk: assert property (@(posedge clk) disable iff (rst)
    (!ab_en_n && !ab_drv_n) |=> (b_oe == '1));
  // R5
  b_drive_off_chk: assert property (@(posedge clk) disable iff (rst)
    (ab_en_n || ab_drv_n) |=> (b_oe == '0));
  // R8
  a_drive_on_chk: assert property (@(posedge clk) disable iff (rst)
    (!ba_en_n && !ba_drv_n) |=> (a_oe == '1));
  // R2
  b_capture_inv_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && !ab_en_n && !ab_ld_n) && (b_oe != '0)) |-> (b_out == ~$past(a_in)));
  // R7
  a_capture_inv_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && !ba_en_n && !ba_ld_n) && (a_oe != '0)) |-> (a_out == ~$past(b_in)));
  // R3
  b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((b_oe != '0) && $past(b_oe != '0) && $past(ab_ld_n || ab_en_n) && $past(!rst))
      |-> $stable(b_out));
  // R7
  a_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((a_oe != '0) && $past(a_oe != '0) && $past(ba_ld_n || ba_en_n) && $past(!rst))
      |-> $stable(a_out));
endmodule

bind inv_latch_xcvr xcvr_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
  .ab_en_n(ab_en_n), .ab_ld_n(ab_ld_n), .ab_drv_n(ab_drv_n),
  .ba_en_n(ba_en_n), .ba_ld_n(ba_ld_n), .ba_drv_n(ba_drv_n)
);

// File: tb/test_inv_latch_xcvr.sv
module test_inv_latch_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic ab_en_n = 1'b1, ab_ld_n = 1'b1, ab_drv_n = 1'b1;
  logic ba_en_n = 1'b1, ba_ld_n = 1'b1, ba_drv_n = 1'b1;

  always #2 clk = ~clk;

  inv_latch_xcvr #(.W(W)) i_inv_latch_xcvr (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_en_n(ab_en_n), .ab_ld_n(ab_ld_n), .ab_drv_n(ab_drv_n),
    .ba_en_n(ba_en_n), .ba_ld_n(ba_ld_n), .ba_drv_n(ba_drv_n)
  );

  // behavioural reference
  int unsigned m_ab = 0, m_ba = 0;
  bit m_drv_ab = 0, m_drv_ba = 0;
  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      m_ab = 0; m_ba = 0; m_drv_ab = 0; m_drv_ba = 0;
    end else begin
      if (ab_en_n == 0 && ab_ld_n == 0) m_ab = int'(a_in);
      if (ba_en_n == 0 && ba_ld_n == 0) m_ba = int'(b_in);
      m_drv_ab = (ab_en_n == 0 && ab_drv_n == 0);
      m_drv_ba = (ba_en_n == 0 && ba_drv_n == 0);
    end
  end

  task automatic chk(string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [W-1:0] eb, ea;
    eb = m_drv_ab ? ~(W'(m_ab)) : '0;
    ea = m_drv_ba ? ~(W'(m_ba)) : '0;
    chk("b_oe",  b_oe,  {W{m_drv_ab}});
    chk("b_out", b_out, eb);
    chk("a_oe",  a_oe,  {W{m_drv_ba}});
    chk("a_out", a_out, ea);
  endtask

  // called at a falling edge: apply, wait one edge, compare
  task automatic step(logic [W-1:0] av, logic [W-1:0] bv,
                      logic [2:0] abc, logic [2:0] bac);
    a_in = av; b_in = bv;
    {ab_en_n, ab_ld_n, ab_drv_n} = abc;
    {ba_en_n, ba_ld_n, ba_drv_n} = bac;
    @(negedge clk);
    compare();
  endtask

  // control codes: {en_n, ld_n, drv_n}
  localparam logic [2:0] OPEN = 3'b000, HOLDDRV = 3'b010, OFF = 3'b111,
                         ENHI = 3'b101, HOLDQ = 3'b011;

  initial begin
    int unsigned cyc = 0;
    fork
      begin
        @(negedge clk); @(negedge clk);
        tag = "R1"; compare();
        rst = 0;
        tag = "R1"; step(8'h00, 8'h00, OFF, OFF);
        // R2 capture and inversion (R6)
        tag = "R2"; step(8'hA5, 8'h00, OPEN, OFF);
        step(8'h3C, 8'h00, OPEN, OFF);
        tag = "R6"; step(8'hFF, 8'h00, OPEN, OFF);
        step(8'h00, 8'h00, OPEN, OFF);
        step(8'h81, 8'h00, OPEN, OFF);
        // R3 hold when load high
        tag = "R3"; step(8'h55, 8'h00, HOLDDRV, OFF);
        step(8'hAA, 8'h00, HOLDDRV, OFF);
        // R4 enable high blocks load and drive
        tag = "R4"; step(8'h12, 8'h00, ENHI, OFF);
        step(8'h34, 8'h00, 3'b100, OFF);
        step(8'h56, 8'h00, HOLDDRV, OFF);
        // R5 drive control
        tag = "R5"; step(8'h56, 8'h00, HOLDQ, OFF);
        step(8'h56, 8'h00, HOLDDRV, OFF);
        // R10 drive off, data changes, load held
        tag = "R10"; step(8'h77, 8'h00, OPEN, OFF);
        step(8'h99, 8'h00, HOLDQ, OFF);
        step(8'hEE, 8'h00, HOLDQ, OFF);
        step(8'hEE, 8'h00, HOLDDRV, OFF);
        // R7/R8 B-to-A path
        tag = "R7"; step(8'h00, 8'hC3, OFF, OPEN);
        step(8'h00, 8'h5A, OFF, OPEN);
        step(8'h00, 8'h11, OFF, HOLDDRV);
        step(8'h00, 8'h22, OFF, ENHI);
        tag = "R8"; step(8'h00, 8'h33, OFF, HOLDDRV);
        step(8'h00, 8'h33, OFF, HOLDQ);
        // R9 both paths at once
        tag = "R9"; step(8'h0F, 8'hF0, OPEN, OPEN);
        step(8'h1E, 8'hE1, OPEN, HOLDDRV);
        step(8'h2D, 8'hD2, HOLDDRV, OPEN);
        step(8'h4B, 8'hB4, ENHI, OPEN);
        for (int i = 0; i < 300; i++) begin
          step(W'($urandom), W'($urandom), 3'($urandom), 3'($urandom));
        end
        // R1 reset mid-run
        tag = "R1"; rst = 1;
        step(8'hFF, 8'hFF, OPEN, OPEN);
        rst = 0;
        step(8'hFF, 8'hFF, HOLDDRV, HOLDDRV);
      end
      begin
        while (cyc < 5000) begin
          @(posedge clk); cyc++;
        end
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule